// File: doc/BRIEF.md
# Last-Outcome Branch Direction Predictor

This block guesses, at fetch time, which way a conditional branch will go, and corrects the guess when the branch resolves late in a five-stage pipeline. The fetch address selects one entry of a direct-mapped table. The entry holds either a single bit that repeats the branch's last direction or a two-bit saturating counter. The fetch side receives a predicted-taken flag and the next address to fetch. The next address is the supplied target when the guess is taken and the sequential address otherwise.

The block carries the guess alongside each fetched instruction through decode and execute into the memory stage. There the real direction arrives and the table entry is trained. If the guess was wrong, the block raises a flush for one cycle. That flush clears the control of the three younger instructions in fetch, decode and execute, and fetch is steered to the correct address. A correct guess costs nothing. A wrong guess costs the same three cycles a full stall would. None of the squashed instructions has reached write-back, so clearing them is always safe.

Top module: `lastdir_predictor`

## Requirements
- R1: After reset every table entry predicts not taken, `slot_live` is 0 and `flush` is 0.
- R2: The entry is selected by address bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). Addresses that differ only outside those bits share one entry.
- R3: With CTR_W = 1 an entry predicts exactly the direction of the most recent resolved branch that mapped to it.
- R4: With CTR_W = 2 an entry is a counter from 0 to 3 that resets to 0. A taken outcome increments it and stops at 3. A not-taken outcome decrements it and stops at 0. The entry predicts taken when the counter is 2 or 3.
- R5: `pred_taken` is 1 only for a valid branch whose entry predicts taken. When `flush` is 0, `fetch_next_pc` is `fetch_target` if `pred_taken` is 1 and `fetch_pc` + 4 otherwise.
- R6: A valid fetch sets `slot_live[0]` on the next clock edge. When no flush occurs in between, it moves to bit 1 and then to bit 2 on the following two edges. Bit 2 is the memory stage, and the fetch-time prediction travels with the instruction.
- R7: A branch in the memory stage whose `mem_taken` equals its fetch-time prediction leaves `flush` at 0 and clears no slot.
- R8: A branch in the memory stage whose `mem_taken` differs from its prediction drives `flush` to 1 in that cycle. In that cycle `fetch_next_pc` is the branch's target if `mem_taken` is 1, and the branch address + 4 if `mem_taken` is 0.
- R9: On the edge after a flush cycle, all three bits of `slot_live` are 0. The instructions in fetch, decode and execute during the flush, including the one presented at fetch, are discarded.
- R10: The table entry is trained on the clock edge that ends the branch's memory-stage cycle. A fetch that reads the same entry in that cycle sees the value from before training.
- R11: Non-branch instructions, empty slots and squashed branches never change the table, whatever `mem_taken` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | An instruction is presented at fetch |
| fetch_is_branch | input | 1 | The fetched instruction is a conditional branch |
| fetch_pc | input | 32 | Address of the fetched instruction |
| fetch_target | input | 32 | Taken target of the fetched branch |
| mem_taken | input | 1 | Real direction of the instruction in the memory stage |
| pred_taken | output | 1 | Fetched branch is predicted taken |
| fetch_next_pc | output | 32 | Next address for fetch |
| flush | output | 1 | Misprediction: squash the younger instructions |
| slot_live | output | RESOLVE_DEPTH | Live flags of decode (bit 0), execute (bit 1) and memory (bit 2) |

## Verification
The bench drives the same branch on consecutive cycles. The fourth fetch then reads an entry in the very cycle the first copy trains it. A design that bypassed the write would predict one step early, and one that trained late would predict one step late. The bench presents a valid fetch during a flush cycle, so a design that let that wrong-path instruction into decode would show a live slot. Non-branches reach the memory stage with `mem_taken` high, and branches alias through low and high address bits, so any stray update or wrong index bit shows up in a later prediction. Running both counter widths side by side shows that the one-bit table flips after a single outcome, while the two-bit one needs two.

// File: rtl/lastdir_pkg.sv
package lastdir_pkg;

    localparam int PC_W       = 32;
    localparam int INSN_BYTES = 4;
    localparam int OFS_W      = 2;

    typedef logic [PC_W-1:0] pc_t;

    // Per-instruction record carried from fetch to the memory stage
    typedef struct packed {
        logic live;
        logic is_br;
        logic pred;
        pc_t  pc;
        pc_t  tgt;
    } slot_t;

    function automatic pc_t seq_pc(input pc_t pc);
        return pc + pc_t'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/lastdir_table.sv
module lastdir_table
    import lastdir_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int CTR_W   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    localparam logic [CTR_W-1:0] CTR_TOP = '1;

    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] cur_val;
    logic [CTR_W-1:0] nxt_val;

    assign cur_val = ctr_q[upd_idx];

    generate
        if (CTR_W == 1) begin : g_last_dir
            // single bit: remember the last outcome
            always_comb nxt_val = upd_taken;
        end else begin : g_saturate
            always_comb begin
                nxt_val = cur_val;
                if (upd_taken && cur_val != CTR_TOP)
                    nxt_val = cur_val + 1'b1;
                else if (!upd_taken && cur_val != '0)
                    nxt_val = cur_val - 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                ctr_q[i] <= '0;
        end else if (upd_en) begin
            ctr_q[upd_idx] <= nxt_val;
        end
    end

    // upper half of the range predicts taken
    assign rd_taken = ctr_q[rd_idx][CTR_W-1];

endmodule

// File: rtl/lastdir_track.sv
module lastdir_track
    import lastdir_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  slot_t f_slot,
    output slot_t stg_o [DEPTH]
);

    slot_t stg_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < DEPTH; i++)
                stg_q[i] <= '0;
        end else begin
            stg_q[0] <= f_slot;
            for (int i = 1; i < DEPTH; i++)
                stg_q[i] <= stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_out
            assign stg_o[g] = stg_q[g];
        end
    endgenerate

endmodule

// File: rtl/lastdir_resolve.sv
module lastdir_resolve
    import lastdir_pkg::*;
(
    input  slot_t m_slot,
    input  logic  taken,
    output logic  mispredict,
    output pc_t   redirect_pc,
    output logic  upd_en,
    output logic  upd_taken
);

    assign upd_en      = m_slot.live & m_slot.is_br;
    assign upd_taken   = taken;
    assign mispredict  = upd_en & (m_slot.pred != taken);
    assign redirect_pc = taken ? m_slot.tgt : seq_pc(m_slot.pc);

endmodule

// File: rtl/lastdir_predictor.sv
module lastdir_predictor
    import lastdir_pkg::*;
#(
    parameter int ENTRIES       = 16,
    parameter int CTR_W         = 2,
    parameter int RESOLVE_DEPTH = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fetch_valid,
    input  logic                     fetch_is_branch,
    input  logic [31:0]              fetch_pc,
    input  logic [31:0]              fetch_target,
    input  logic                     mem_taken,
    output logic                     pred_taken,
    output logic [31:0]              fetch_next_pc,
    output logic                     flush,
    output logic [RESOLVE_DEPTH-1:0] slot_live
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int LAST  = RESOLVE_DEPTH - 1;

    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] upd_idx;
    logic             tab_taken;
    logic             upd_en;
    logic             upd_taken;
    logic             mispredict;
    pc_t              redirect_pc;
    slot_t            fetch_slot;
    slot_t            stg [RESOLVE_DEPTH];

    assign fetch_idx = fetch_pc[OFS_W +: IDX_W];
    assign upd_idx   = stg[LAST].pc[OFS_W +: IDX_W];

    lastdir_table #(
        .ENTRIES (ENTRIES),
        .CTR_W   (CTR_W)
    ) i_table (
        .clk       (clk),
        .rst       (rst),
        .rd_idx    (fetch_idx),
        .rd_taken  (tab_taken),
        .upd_en    (upd_en),
        .upd_idx   (upd_idx),
        .upd_taken (upd_taken)
    );

    assign pred_taken = fetch_valid & fetch_is_branch & tab_taken;

    always_comb begin
        fetch_slot       = '0;
        fetch_slot.live  = fetch_valid;
        fetch_slot.is_br = fetch_is_branch;
        fetch_slot.pred  = pred_taken;
        fetch_slot.pc    = fetch_pc;
        fetch_slot.tgt   = fetch_target;
    end

    lastdir_track #(
        .DEPTH (RESOLVE_DEPTH)
    ) i_track (
        .clk    (clk),
        .rst    (rst),
        .flush  (mispredict),
        .f_slot (fetch_slot),
        .stg_o  (stg)
    );

    lastdir_resolve i_resolve (
        .m_slot      (stg[LAST]),
        .taken       (mem_taken),
        .mispredict  (mispredict),
        .redirect_pc (redirect_pc),
        .upd_en      (upd_en),
        .upd_taken   (upd_taken)
    );

    always_comb begin
        if (mispredict)
            fetch_next_pc = redirect_pc;
        else if (pred_taken)
            fetch_next_pc = fetch_target;
        else
            fetch_next_pc = seq_pc(fetch_pc);
    end

    assign flush = mispredict;

    generate
        for (genvar g = 0; g < RESOLVE_DEPTH; g++) begin : g_live
            assign slot_live[g] = stg[g].live;
        end
    endgenerate

endmodule

// File: rtl/lastdir_checks.sv
module lastdir_checks #(
    parameter int DEPTH = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic             fetch_is_branch,
    input logic [31:0]      fetch_pc,
    input logic [31:0]      fetch_target,
    input logic             pred_taken,
    input logic [31:0]      fetch_next_pc,
    input logic             flush,
    input logic [DEPTH-1:0] slot_live
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (slot_live == '0 && !flush));

    assert_pred_branch_only_R5: assert property (@(posedge clk) disable iff (rst)
        pred_taken |-> (fetch_valid && fetch_is_branch));

    assert_taken_steer_R5: assert property (@(posedge clk) disable iff (rst)
        (pred_taken && !flush) |-> (fetch_next_pc == fetch_target));

    assert_seq_steer_R5: assert property (@(posedge clk) disable iff (rst)
        (!pred_taken && !flush) |-> (fetch_next_pc == fetch_pc + 32'd4));

    assert_slot_advance_R6: assert property (@(posedge clk) disable iff (rst)
        !flush |=> (slot_live[DEPTH-1:1] == $past(slot_live[DEPTH-2:0])));

    assert_flush_from_mem_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> slot_live[DEPTH-1]);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (slot_live == '0));

endmodule

bind lastdir_predictor lastdir_checks #(.DEPTH(RESOLVE_DEPTH)) i_lastdir_checks (
    .clk             (clk),
    .rst             (rst),
    .fetch_valid     (fetch_valid),
    .fetch_is_branch (fetch_is_branch),
    .fetch_pc        (fetch_pc),
    .fetch_target    (fetch_target),
    .pred_taken      (pred_taken),
    .fetch_next_pc   (fetch_next_pc),
    .flush           (flush),
    .slot_live       (slot_live)
);

// File: tb/test_lastdir_predictor.sv
module test_lastdir_predictor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fv  = 1'b0;
    logic        fb  = 1'b0;
    logic [31:0] fpc = '0;
    logic [31:0] ftg = '0;
    logic        mt  [2];
    logic        pt  [2];
    logic [31:0] nx  [2];
    logic        fl  [2];
    logic [2:0]  sl  [2];

    int  nvec = 0;
    int  nbad = 0;
    bit  done = 1'b0;

    // bench model: k = 0 two-bit instance, k = 1 one-bit instance
    int          ctr  [2][16];
    bit          mlive[2][3];
    bit          mbr  [2][3];
    bit          mpred[2][3];
    logic [31:0] mpc  [2][3];
    logic [31:0] mtg  [2][3];
    bit          truth[64];

    always #5 clk = ~clk;

    lastdir_predictor #(.CTR_W(2)) i_lastdir_predictor (
        .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_is_branch(fb),
        .fetch_pc(fpc), .fetch_target(ftg), .mem_taken(mt[0]),
        .pred_taken(pt[0]), .fetch_next_pc(nx[0]), .flush(fl[0]), .slot_live(sl[0]));

    lastdir_predictor #(.CTR_W(1)) i_lastdir_predictor_one (
        .clk(clk), .rst(rst), .fetch_valid(fv), .fetch_is_branch(fb),
        .fetch_pc(fpc), .fetch_target(ftg), .mem_taken(mt[1]),
        .pred_taken(pt[1]), .fetch_next_pc(nx[1]), .flush(fl[1]), .slot_live(sl[1]));

    task automatic chk(input string tag, input int k, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s inst%0d %s: actual %h expected %h", tag, k, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < 16; i++) ctr[k][i] = 0;
            for (int s = 0; s < 3; s++) begin
                mlive[k][s] = 0; mbr[k][s] = 0; mpred[k][s] = 0;
                mpc[k][s] = '0; mtg[k][s] = '0;
            end
        end
    endtask

    // One pipeline cycle: drive, check all outputs, then advance the model
    task automatic cycle(input bit v, input bit b, input logic [31:0] pc,
                         input logic [31:0] tg, input string tag);
        bit          ep   [2];
        bit          emis [2];
        logic [31:0] enx  [2];
        @(negedge clk);
        fv = v; fb = b; fpc = pc; ftg = tg;
        for (int k = 0; k < 2; k++)
            mt[k] = truth[mpc[k][2][7:2]];
        #2;
        for (int k = 0; k < 2; k++) begin
            ep[k]   = v && b && (ctr[k][pc[5:2]] >= ((k == 0) ? 2 : 1));
            emis[k] = mlive[k][2] && mbr[k][2] && (mpred[k][2] != mt[k]);
            if (emis[k])      enx[k] = mt[k] ? mtg[k][2] : mpc[k][2] + 32'd4;
            else if (ep[k])   enx[k] = tg;
            else              enx[k] = pc + 32'd4;
            chk(tag, k, "pred_taken", {31'b0, pt[k]}, {31'b0, ep[k]});
            chk(tag, k, "flush", {31'b0, fl[k]}, {31'b0, emis[k]});
            chk(tag, k, "fetch_next_pc", nx[k], enx[k]);
            chk(tag, k, "slot_live", {29'b0, sl[k]},
                {29'b0, mlive[k][2], mlive[k][1], mlive[k][0]});
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (mlive[k][2] && mbr[k][2]) begin
                int ix = mpc[k][2][5:2];
                if (k == 1) ctr[k][ix] = mt[k] ? 1 : 0;
                else if (mt[k] && ctr[k][ix] < 3) ctr[k][ix]++;
                else if (!mt[k] && ctr[k][ix] > 0) ctr[k][ix]--;
            end
            if (emis[k]) begin
                for (int s = 0; s < 3; s++) begin
                    mlive[k][s] = 0; mbr[k][s] = 0; mpred[k][s] = 0;
                    mpc[k][s] = '0; mtg[k][s] = '0;
                end
            end else begin
                for (int s = 2; s > 0; s--) begin
                    mlive[k][s] = mlive[k][s-1]; mbr[k][s] = mbr[k][s-1];
                    mpred[k][s] = mpred[k][s-1]; mpc[k][s] = mpc[k][s-1];
                    mtg[k][s] = mtg[k][s-1];
                end
                mlive[k][0] = v; mbr[k][0] = b; mpred[k][0] = ep[k];
                mpc[k][0] = pc; mtg[k][0] = tg;
            end
        end
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, 32'h0, 32'h0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; fv = 0; fb = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // R1: all entries start not taken, pipeline empty
    task automatic t_reset_sweep();
        do_reset();
        for (int i = 0; i < 64; i++) truth[i] = 0;
        cycle(1'b0, 1'b0, 32'h0, 32'h0, "R1");
        for (int i = 0; i < 16; i++)
            cycle(1'b1, 1'b1, 32'(i * 4), 32'h300, "R1");
        drain("R1");
    endtask

    // R3 and R4: one-bit flips after one outcome, two-bit needs two
    task automatic t_widths();
        truth[4] = 1;
        for (int n = 0; n < 4; n++) begin
            cycle(1'b1, 1'b1, 32'h10, 32'h120, "R3/R4");
            drain("R3/R4");
        end
        truth[4] = 0;
        for (int n = 0; n < 4; n++) begin
            cycle(1'b1, 1'b1, 32'h10, 32'h120, "R3/R4");
            drain("R3/R4");
        end
        cycle(1'b1, 1'b1, 32'h10, 32'h120, "R3/R4");
        drain("R3/R4");
    endtask

    // R5 and R8: steering on a taken guess, redirect on each kind of miss
    task automatic t_steer();
        truth[8] = 1;
        for (int n = 0; n < 3; n++) begin
            cycle(1'b1, 1'b1, 32'h20, 32'h200, "R5/R8");
            cycle(1'b1, 1'b0, 32'h24, 32'h0, "R5/R8");
            cycle(1'b1, 1'b0, 32'h28, 32'h0, "R5/R8");
            cycle(1'b1, 1'b0, 32'h2c, 32'h0, "R5/R8");
        end
        truth[8] = 0;
        for (int n = 0; n < 3; n++) begin
            cycle(1'b1, 1'b1, 32'h20, 32'h200, "R5/R8");
            drain("R5/R8");
        end
    endtask

    // R6, R7, R9, R10: back-to-back copies of one branch; fetch during flush;
    // fourth fetch reads the entry in the cycle the first copy trains it
    task automatic t_back_to_back();
        truth[12] = 1;
        for (int n = 0; n < 10; n++)
            cycle(1'b1, 1'b1, 32'h30, 32'h400, "R6/R7/R9/R10");
        drain("R6/R7/R9/R10");
        truth[12] = 0;
        for (int n = 0; n < 10; n++)
            cycle(1'b1, 1'b1, 32'h30, 32'h400, "R6/R7/R9/R10");
        drain("R6/R7/R9/R10");
    endtask

    // R2: aliasing through high bits and low offset bits
    task automatic t_alias();
        truth[17] = 1;   // address 0x44, index 1
        truth[33] = 0;   // address 0x84, index 1
        for (int n = 0; n < 2; n++) begin
            cycle(1'b1, 1'b1, 32'h44, 32'h500, "R2");
            drain("R2");
        end
        cycle(1'b1, 1'b1, 32'h84, 32'h600, "R2");
        drain("R2");
        cycle(1'b1, 1'b1, 32'h47, 32'h700, "R2");
        drain("R2");
    endtask

    // R11: non-branches and empty slots with mem_taken high leave entries alone
    task automatic t_no_update();
        truth[18] = 1;   // address 0x48, index 2
        for (int n = 0; n < 6; n++)
            cycle(1'b1, 1'b0, 32'h48, 32'h0, "R11");
        drain("R11");
        cycle(1'b0, 1'b1, 32'h48, 32'h800, "R11");
        drain("R11");
        truth[18] = 0;
        cycle(1'b1, 1'b1, 32'h48, 32'h800, "R11");
        drain("R11");
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        mt[0] = 1'b0; mt[1] = 1'b0;
        for (int i = 0; i < 64; i++) truth[i] = 0;
        model_clear();
        t_reset_sweep();
        t_widths();
        t_steer();
        t_back_to_back();
        t_alias();
        t_no_update();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

endmodule